// File: doc/BRIEF.md
# SDRAM Bank Open-Row Manager

This block sits between a request decoder and an SDRAM transfer engine. It accepts requests that are already split into bank, row and column. For each of four banks it records whether a row is open and which one. Each accepted request is held in a one-entry slot for its bank. The block then works out what that bank needs next. A bank with no open row needs an activate. A bank open on another row needs a precharge first. A bank open on the requested row is a page hit and goes straight to read/write.

The next command of each bank is offered to the transfer engine through a valid/acknowledge pair. The block enforces three programmable delays, each given in clock cycles: activate to precharge, precharge to activate, and activate to read/write. A per-bank precharge permission input lets the transfer side hold off any close. A refresh input forces every bank closed. A request may also carry a close flag, which makes its bank precharge once the transfer has been issued.

The block applies no ordering between banks beyond a fixed priority by bank number. A command counts as taken in a cycle where both `xfr_valid` and `xfr_ack` are high. The offered command may change before it is acknowledged, when a lower-numbered bank becomes eligible.

Top module: `sdram_bank_mgr`

## Requirements
- R1: After reset no command is offered (`xfr_valid` low), `req_ready` is high, and every bank is closed.
- R2: A request to a closed bank first yields an activate (`xfr_cmd` = 01) carrying the row on `xfr_addr`. After that comes a read/write (`xfr_cmd` = 00) carrying the column zero-extended on `xfr_addr`, with the request's write flag on `xfr_write`.
- R3: A request whose row equals the open row of its bank is a page hit and yields a read/write with no activate before it.
- R4: A request to a bank open on a different row yields a precharge (`xfr_cmd` = 10, `xfr_addr` zero), then an activate of the new row, then the read/write.
- R5: A read/write to a bank is acknowledged no sooner than max(`cfg_trcd`,1) cycles after that bank's activate was acknowledged.
- R6: An activate to a bank is acknowledged no sooner than max(`cfg_trp`,1) cycles after that bank's precharge was acknowledged.
- R7: A precharge to a bank is acknowledged no sooner than max(`cfg_tras`,1) cycles after that bank's activate was acknowledged.
- R8: No precharge is offered to bank b while `pre_ok[b]` is low.
- R9: A request with `req_close` set causes its bank to be precharged after its read/write, so a later request to the same row needs a fresh activate.
- R10: With `cfg_depth` = d, `req_ready` is low while d+1 requests are pending (d = 3 allows four).
- R11: A request to a bank whose slot is still occupied is refused (`req_ready` low) until that slot's read/write has been acknowledged.
- R12: While `refresh` is high no command is offered and all banks become closed, so the next request to a formerly open row needs an activate.
- R13: When several banks have an eligible command, the lowest-numbered bank is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | 2 | Pending-request limit minus one |
| cfg_tras | input | 4 | Activate-to-precharge delay in cycles |
| cfg_trp | input | 4 | Precharge-to-activate delay in cycles |
| cfg_trcd | input | 4 | Activate-to-read/write delay in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when both are high |
| req_bank | input | 2 | Request bank |
| req_row | input | 13 | Request row |
| req_col | input | 11 | Request column |
| req_write | input | 1 | 1 write, 0 read |
| req_close | input | 1 | Close the bank after this transfer |
| refresh | input | 1 | Refresh in progress: close all banks |
| pre_ok | input | 4 | Per-bank permission to precharge |
| xfr_valid | output | 1 | Command offered |
| xfr_ack | input | 1 | Command taken |
| xfr_cmd | output | 2 | 00 read/write, 01 activate, 10 precharge |
| xfr_bank | output | 2 | Command bank |
| xfr_addr | output | 13 | Row for activate, column for read/write, zero for precharge |
| xfr_write | output | 1 | Write flag of a read/write |

## Verification
Two collisions matter most. The first is a request being accepted into a bank's slot in the same cycle that another bank's command is acknowledged. The bench provokes it by sending a miss request while a timer of the same bank is still running, and then measures the acknowledge spacing against the programmed delays. The second is several banks becoming eligible in one cycle. The bench provokes it by queuing requests under `refresh` and then releasing it. It judges the result by the order of the commands offered, lowest bank first, with a lower bank's read/write cutting ahead of a higher bank's activate.

// File: rtl/bank_mgr_pkg.sv
`timescale 1ns/1ps
package bank_mgr_pkg;
    typedef enum logic [1:0] {
        XC_RW  = 2'b00,
        XC_ACT = 2'b01,
        XC_PRE = 2'b10
    } xcmd_e;
endpackage

// File: rtl/bank_mgr_bank.sv
`timescale 1ns/1ps
module bank_mgr_bank
    import bank_mgr_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 11,
    parameter int TW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    cfg_tras,
    input  logic [TW-1:0]    cfg_trp,
    input  logic [TW-1:0]    cfg_trcd,
    input  logic             load,
    input  logic [ROW_W-1:0] ld_row,
    input  logic [COL_W-1:0] ld_col,
    input  logic             ld_write,
    input  logic             ld_close,
    input  logic             refresh,
    input  logic             pre_ok,
    input  logic             grant,
    output logic             busy,
    output logic             want,
    output xcmd_e            cmd,
    output logic [ROW_W-1:0] addr,
    output logic             write
);
    typedef struct packed {
        logic             pend;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr;
        logic             cl;
        logic             open;
        logic [ROW_W-1:0] orow;
        logic             shut;
        logic [TW-1:0]    tras;
        logic [TW-1:0]    trp;
        logic [TW-1:0]    trcd;
    } bank_st_t;

    bank_st_t s_d, s_q;

    function automatic logic [TW-1:0] start_cnt(input logic [TW-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    function automatic logic [TW-1:0] tick(input logic [TW-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    logic hit, tras_done, trp_done, trcd_done;

    always_comb begin
        hit       = s_q.open && (s_q.orow == s_q.row);
        tras_done = (s_q.tras == '0);
        trp_done  = (s_q.trp == '0);
        trcd_done = (s_q.trcd == '0);
        want = 1'b0;
        cmd  = XC_RW;
        addr = '0;
        if (s_q.shut) begin
            cmd  = XC_PRE;
            want = s_q.open && tras_done && pre_ok;
        end else if (s_q.pend) begin
            if (!s_q.open) begin
                cmd  = XC_ACT;
                addr = s_q.row;
                want = trp_done;
            end else if (hit) begin
                cmd  = XC_RW;
                addr = ROW_W'(s_q.col);
                want = trcd_done;
            end else begin
                cmd  = XC_PRE;
                want = tras_done && pre_ok;
            end
        end
        busy  = s_q.pend;
        write = s_q.wr;
    end

    always_comb begin
        s_d      = s_q;
        s_d.tras = tick(s_q.tras);
        s_d.trp  = tick(s_q.trp);
        s_d.trcd = tick(s_q.trcd);
        if (grant) begin
            case (cmd)
                XC_ACT: begin
                    s_d.open = 1'b1;
                    s_d.orow = s_q.row;
                    s_d.tras = start_cnt(cfg_tras);
                    s_d.trcd = start_cnt(cfg_trcd);
                end
                XC_PRE: begin
                    s_d.open = 1'b0;
                    s_d.shut = 1'b0;
                    s_d.trp  = start_cnt(cfg_trp);
                end
                default: begin
                    s_d.pend = 1'b0;
                    s_d.shut = s_q.cl;
                end
            endcase
        end
        if (refresh) begin
            s_d.open = 1'b0;
            s_d.shut = 1'b0;
            s_d.trp  = start_cnt(cfg_trp);
        end
        if (load) begin
            s_d.pend = 1'b1;
            s_d.row  = ld_row;
            s_d.col  = ld_col;
            s_d.wr   = ld_write;
            s_d.cl   = ld_close;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: no read/write in the cycle after an activate when tRCD exceeds one
    a_r5_trcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cmd == XC_ACT && cfg_trcd > 1) |=> !(want && cmd == XC_RW));
    // R6: no activate in the cycle after a precharge when tRP exceeds one
    a_r6_trp_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cmd == XC_PRE && cfg_trp > 1) |=> !(want && cmd == XC_ACT));
    // R7: no precharge in the cycle after an activate when tRAS exceeds one
    a_r7_tras_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cmd == XC_ACT && cfg_tras > 1) |=> !(want && cmd == XC_PRE));
    // R9: a read/write with the close flag leaves the bank waiting to precharge
    a_r9_close_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cmd == XC_RW && s_q.cl && !refresh) |=> (s_q.shut && s_q.open));
endmodule

// File: rtl/bank_mgr_arb.sv
`timescale 1ns/1ps
module bank_mgr_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] offer,
    output logic [N-1:0] pick
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (offer[i]) pick = N'(1) << i;
        end
    end
endmodule

// File: rtl/sdram_bank_mgr.sv
`timescale 1ns/1ps
module sdram_bank_mgr
    import bank_mgr_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 11,
    parameter int TW    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_depth,
    input  logic [TW-1:0]            cfg_tras,
    input  logic [TW-1:0]            cfg_trp,
    input  logic [TW-1:0]            cfg_trcd,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    input  logic                     req_write,
    input  logic                     req_close,
    input  logic                     refresh,
    input  logic [BANKS-1:0]         pre_ok,
    output logic                     xfr_valid,
    input  logic                     xfr_ack,
    output logic [1:0]               xfr_cmd,
    output logic [$clog2(BANKS)-1:0] xfr_bank,
    output logic [ROW_W-1:0]         xfr_addr,
    output logic                     xfr_write
);
    localparam int BW    = $clog2(BANKS);
    localparam int CNT_W = $clog2(BANKS + 1);

    logic [BANKS-1:0] busy, want, offer, pick, load, grant, wr_a;
    xcmd_e            cmd_a  [BANKS];
    logic [ROW_W-1:0] addr_a [BANKS];
    logic [CNT_W-1:0] pending;

    always_comb begin
        pending = '0;
        for (int b = 0; b < BANKS; b++) pending = pending + CNT_W'(busy[b]);
        req_ready = !busy[req_bank] && (pending <= CNT_W'(cfg_depth));
        offer     = want & {BANKS{!refresh}};
    end

    genvar g;
    generate
        for (g = 0; g < BANKS; g++) begin : g_bank
            assign load[g]  = req_valid && req_ready && (req_bank == BW'(g));
            assign grant[g] = pick[g] && xfr_ack;
            bank_mgr_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_tras (cfg_tras),
                .cfg_trp  (cfg_trp),
                .cfg_trcd (cfg_trcd),
                .load     (load[g]),
                .ld_row   (req_row),
                .ld_col   (req_col),
                .ld_write (req_write),
                .ld_close (req_close),
                .refresh  (refresh),
                .pre_ok   (pre_ok[g]),
                .grant    (grant[g]),
                .busy     (busy[g]),
                .want     (want[g]),
                .cmd      (cmd_a[g]),
                .addr     (addr_a[g]),
                .write    (wr_a[g])
            );
        end
    endgenerate

    bank_mgr_arb #(.N(BANKS)) u_arb (
        .offer (offer),
        .pick  (pick)
    );

    always_comb begin
        xfr_valid = |pick;
        xfr_cmd   = XC_RW;
        xfr_bank  = '0;
        xfr_addr  = '0;
        xfr_write = 1'b0;
        for (int b = 0; b < BANKS; b++) begin
            if (pick[b]) begin
                xfr_cmd   = cmd_a[b];
                xfr_bank  = BW'(b);
                xfr_addr  = addr_a[b];
                xfr_write = wr_a[b];
            end
        end
    end

    // R8: a precharge is only offered to a bank whose permission is high
    a_r8_pre_permit: assert property (@(posedge clk) disable iff (!rst_n)
        (xfr_valid && xfr_cmd == XC_PRE) |-> pre_ok[xfr_bank]);
    // R12: refresh silences the command port
    a_r12_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> !xfr_valid);
    // R13: no lower-numbered bank with an eligible command is passed over
    a_r13_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        xfr_valid |-> ((offer & ((BANKS'(1) << xfr_bank) - 1'b1)) == '0));
    // R10: an acceptance never takes the pending count past the limit
    a_r10_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && $stable(cfg_depth)) |=>
            (pending <= CNT_W'(cfg_depth) + CNT_W'(1)));
    // R2: the command code is never the unused value
    a_r2_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        xfr_valid |-> (xfr_cmd != 2'b11));
endmodule

// File: tb/sdram_bank_mgr_bench.sv
`timescale 1ns/1ps
module sdram_bank_mgr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_depth = 2'd3;
    logic [3:0]  cfg_tras = 4'd1, cfg_trp = 4'd1, cfg_trcd = 4'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [10:0] req_col = '0;
    logic        req_write = 1'b0, req_close = 1'b0;
    logic        refresh = 1'b0;
    logic [3:0]  pre_ok = 4'hF;
    logic        xfr_valid, xfr_ack = 1'b0;
    logic [1:0]  xfr_cmd, xfr_bank;
    logic [12:0] xfr_addr;
    logic        xfr_write;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;
    int last_wr;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_bank_mgr u_sdram_bank_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_tras(cfg_tras),
        .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .req_valid(req_valid),
        .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_write(req_write), .req_close(req_close),
        .refresh(refresh), .pre_ok(pre_ok), .xfr_valid(xfr_valid),
        .xfr_ack(xfr_ack), .xfr_cmd(xfr_cmd), .xfr_bank(xfr_bank),
        .xfr_addr(xfr_addr), .xfr_write(xfr_write)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input int b, input int row, input int col,
                        input bit wr, input bit cl, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(b); req_row = 13'(row);
        req_col = 11'(col); req_write = wr; req_close = cl;
        #1 chk({tag, " req_ready"}, int'(req_ready), 1);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic try_req(input int b, input int row, output bit acc);
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(b); req_row = 13'(row);
        req_col = '0; req_write = 1'b0; req_close = 1'b0;
        #1 acc = req_ready;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // waits for an offered command, checks it, acknowledges it
    task automatic take(input int c, input int b, input int a,
                        input string tag, output int at);
        int w = 0;
        at = -1;
        while (1) begin
            @(negedge clk);
            #1;
            if (xfr_valid) break;
            w++;
            if (w > 60) begin
                chk({tag, " command timeout"}, 0, 1);
                return;
            end
        end
        chk({tag, " cmd"}, int'(xfr_cmd), c);
        chk({tag, " bank"}, int'(xfr_bank), b);
        chk({tag, " addr"}, int'(xfr_addr), a);
        last_wr = int'(xfr_write);
        at = cyc;
        xfr_ack = 1'b1;
        @(posedge clk);
        #1 xfr_ack = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n) begin
            @(negedge clk);
            #1 xfr_ack = xfr_valid;
            @(posedge clk);
            #1 xfr_ack = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1 xfr_valid after reset", int'(xfr_valid), 0);
        chk("R1 req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_idle_bank();
        int t;
        send(0, 'h12, 5, 1, 0, "R2");
        take(1, 0, 'h12, "R2 activate", t);
        take(0, 0, 5, "R2 read/write", t);
        chk("R2 write flag", last_wr, 1);
    endtask

    task automatic t_hit();
        int t;
        send(0, 'h12, 7, 0, 0, "R3");
        take(0, 0, 7, "R3 hit goes to read/write", t);
        chk("R3 read flag", last_wr, 0);
    endtask

    task automatic t_miss_permit();
        int t, seen = 0;
        pre_ok = 4'hE;
        send(0, 'h20, 1, 0, 0, "R4");
        repeat (6) begin
            @(negedge clk); #1;
            if (xfr_valid) seen++;
        end
        chk("R8 no precharge while pre_ok low", seen, 0);
        pre_ok = 4'hF;
        take(2, 0, 0, "R4 precharge", t);
        take(1, 0, 'h20, "R4 activate new row", t);
        take(0, 0, 1, "R4 read/write", t);
    endtask

    task automatic t_delays();
        int t0, t1, t2, t3, t4;
        cfg_trcd = 4'd3; cfg_tras = 4'd6; cfg_trp = 4'd5;
        send(2, 1, 0, 0, 0, "R5");
        take(1, 2, 1, "R5 activate", t0);
        take(0, 2, 0, "R5 read/write", t1);
        chk("R5 tRCD spacing", t1 - t0, 3);
        send(2, 9, 4, 0, 0, "R7");
        take(2, 2, 0, "R7 precharge", t2);
        chk("R7 tRAS spacing", t2 - t0, 6);
        take(1, 2, 9, "R6 activate", t3);
        chk("R6 tRP spacing", t3 - t2, 5);
        take(0, 2, 4, "R6 read/write", t4);
        cfg_trcd = 4'd1; cfg_tras = 4'd1; cfg_trp = 4'd1;
    endtask

    task automatic t_close();
        int t;
        send(1, 5, 3, 1, 1, "R9");
        take(1, 1, 5, "R9 activate", t);
        take(0, 1, 3, "R9 read/write", t);
        take(2, 1, 0, "R9 automatic precharge", t);
        send(1, 5, 6, 0, 0, "R9 reopen");
        take(1, 1, 5, "R9 same row needs activate", t);
        take(0, 1, 6, "R9 read/write", t);
    endtask

    task automatic t_priority_refresh();
        int t, seen = 0;
        @(negedge clk);
        refresh = 1'b1;
        send(3, 7, 0, 0, 0, "R13");
        send(1, 8, 0, 0, 0, "R13");
        repeat (3) begin
            @(negedge clk); #1;
            if (xfr_valid) seen++;
        end
        chk("R12 nothing offered during refresh", seen, 0);
        @(negedge clk);
        refresh = 1'b0;
        take(1, 1, 8, "R13 lower bank activates first", t);
        take(0, 1, 0, "R13 lower bank read/write ahead", t);
        take(1, 3, 7, "R13 higher bank activate", t);
        take(0, 3, 0, "R13 higher bank read/write", t);
        send(0, 'h20, 2, 0, 0, "R12");
        take(1, 0, 'h20, "R12 row closed by refresh", t);
        take(0, 0, 2, "R12 read/write", t);
    endtask

    task automatic t_depth_stall();
        bit acc;
        @(negedge clk);
        refresh = 1'b1;
        cfg_depth = 2'd1;
        send(0, 1, 0, 0, 0, "R10");
        send(1, 1, 0, 0, 0, "R10");
        try_req(2, 1, acc);
        chk("R10 refused at depth limit", int'(acc), 0);
        cfg_depth = 2'd3;
        try_req(2, 1, acc);
        chk("R10 third accepted at larger depth", int'(acc), 1);
        try_req(2, 2, acc);
        chk("R11 second request to busy bank refused", int'(acc), 0);
        try_req(3, 1, acc);
        chk("R10 fourth accepted at depth 3", int'(acc), 1);
        @(negedge clk);
        refresh = 1'b0;
        drain(40);
        @(negedge clk); #1;
        chk("R11 all drained", int'(xfr_valid), 0);
        chk("R11 ready after drain", int'(req_ready), 1);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_idle_bank();
        t_hit();
        t_miss_permit();
        t_delays();
        t_close();
        t_priority_refresh();
        t_depth_stall();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule